// File: doc/BRIEF.md
# Block Address Translator

This unit maps a 32-bit effective address onto a physical page address using a small bank of block-translation entries. Two independent banks exist: one consulted for instruction fetches and one for data accesses. Each entry is a pair of 32-bit words, an upper (match) word and a lower (target) word. Software-visible configuration is loaded through a single-word write port that picks bank, entry index and which word of the pair.

A lookup is presented with the effective address, the access kind and the privilege state. The selected bank is searched combinationally, the lowest-numbered matching entry supplies the physical page address and the granted permissions, and the result is registered, so the response appears one clock after the request. When no entry matches, a miss is flagged and the full effective address is latched into a fault-address register that holds its value until the next miss.

Top module: `bat_xlate`

## Requirements
- R1: After synchronous reset every entry word is zero, all response outputs are low, the fault address is zero, and any lookup misses.
- R2: A request with `req_fetch`=1 searches only the instruction bank (write select `cfg_wr_dset`=0); `req_fetch`=0 searches only the data bank (`cfg_wr_dset`=1).
- R3: An entry can match only if address bits 31:28 equal upper-word bits 31:28.
- R4: The length mask is upper-word bits 12:2 placed at positions 27:17; address bits 27:17 with the mask bits forced to zero must equal upper-word bits 27:17.
- R5: An entry is eligible in supervisor state (`req_user`=0) only when upper-word bit 1 is set, and in user state (`req_user`=1) only when upper-word bit 0 is set.
- R6: On a hit the physical address is lower-word bits 31:28, then lower-word bits 27:17 ORed with the address bits 27:17 selected by the mask, then address bits 16:12, with bits 11:0 zero.
- R7: Lower-word bit 1 grants read and write; otherwise bit 0 grants read only; with both clear the access still hits but neither permission is granted.
- R8: When several entries of the bank match, the one with the smallest index provides the result.
- R9: On a miss `rsp_miss`=1, `rsp_hit`=0, physical address and permissions are zero, and `fault_addr` takes the request's effective address.
- R10: The response for a request appears exactly one cycle after it with `rsp_valid`=1; a cycle without a request produces `rsp_valid`, `rsp_hit` and `rsp_miss` all low.
- R11: `fault_addr` keeps its value on hits and on idle cycles.
- R12: A configuration write takes effect for lookups issued after the write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_dset | input | 1 | Bank select for the write: 0 instruction, 1 data |
| cfg_wr_idx | input | IDX_W | Entry index for the write |
| cfg_wr_upper | input | 1 | 1 writes the upper (match) word, 0 the lower (target) word |
| cfg_wr_data | input | 32 | Word to write |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Effective address |
| req_fetch | input | 1 | 1 for instruction fetch, 0 for data access |
| req_user | input | 1 | 1 for user state, 0 for supervisor |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | An entry matched |
| rsp_miss | output | 1 | No entry matched |
| rsp_paddr | output | 32 | Physical page address |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| fault_addr | output | 32 | Effective address of the latest miss |

## Verification
The bench builds the unit with the default of four entries per bank, so every index, including the last one, can be programmed and made to compete with entry 0 for priority. With four entries it reaches a full-mask block, a two-bit partial mask and a zero mask side by side in one bank, and the same address resolved differently by the two banks. Priority is exercised by having entries 1 and 3 both match, then disqualifying entry 1 through its privilege bits alone.

// File: rtl/bat_pkg.sv
package bat_pkg;

    localparam int ADDR_W = 32;

    // Upper (match) word layout
    typedef struct packed {
        logic [3:0]  eff_hi;     // 31:28
        logic [10:0] eff_blk;    // 27:17
        logic [3:0]  rsvd;       // 16:13
        logic [10:0] len_mask;   // 12:2
        logic        sup_ok;     // 1
        logic        usr_ok;     // 0
    } upper_word_t;

    // Lower (target) word layout
    typedef struct packed {
        logic [3:0]  phys_hi;    // 31:28
        logic [10:0] phys_blk;   // 27:17
        logic [14:0] rsvd;       // 16:2
        logic        allow_rw;   // 1
        logic        allow_ro;   // 0
    } lower_word_t;

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] paddr;
        logic              rd;
        logic              wr;
    } xlate_res_t;

    function automatic logic entry_hits(upper_word_t up, logic [ADDR_W-1:0] ea,
                                        logic user);
        logic hi_eq, blk_eq, priv_ok;
        hi_eq   = (ea[31:28] == up.eff_hi);
        blk_eq  = ((ea[27:17] & ~up.len_mask) == up.eff_blk);
        priv_ok = user ? up.usr_ok : up.sup_ok;
        return hi_eq && blk_eq && priv_ok;
    endfunction

    function automatic xlate_res_t entry_translate(upper_word_t up, lower_word_t lo,
                                                   logic [ADDR_W-1:0] ea);
        xlate_res_t r;
        r.hit   = 1'b1;
        r.paddr = {lo.phys_hi, lo.phys_blk | (ea[27:17] & up.len_mask),
                   ea[16:12], 12'h000};
        r.rd    = lo.allow_rw | lo.allow_ro;
        r.wr    = lo.allow_rw;
        return r;
    endfunction

endpackage

// File: rtl/bat_entry_bank.sv
module bat_entry_bank
    import bat_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_dset,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_upper,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              rd_dset,
    output upper_word_t       sel_up [NUM_ENTRIES],
    output lower_word_t       sel_lo [NUM_ENTRIES]
);
    localparam int NUM_SETS = 2;

    upper_word_t up_q [NUM_SETS][NUM_ENTRIES];
    lower_word_t lo_q [NUM_SETS][NUM_ENTRIES];

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
            logic sel;
            assign sel = wr_en && (wr_dset == 1'(s)) && (wr_idx == IDX_W'(e));
            always_ff @(posedge clk) begin
                if (rst) begin
                    up_q[s][e] <= '0;
                    lo_q[s][e] <= '0;
                end else if (sel) begin
                    if (wr_upper) up_q[s][e] <= upper_word_t'(wr_data);
                    else          lo_q[s][e] <= lower_word_t'(wr_data);
                end
            end
        end
    end

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_rd
        assign sel_up[e] = rd_dset ? up_q[1][e] : up_q[0][e];
        assign sel_lo[e] = rd_dset ? lo_q[1][e] : lo_q[0][e];
    end

endmodule

// File: rtl/bat_match_array.sv
module bat_match_array
    import bat_pkg::*;
#(
    parameter int NUM_ENTRIES = 4
) (
    input  upper_word_t       ent_up [NUM_ENTRIES],
    input  lower_word_t       ent_lo [NUM_ENTRIES],
    input  logic [ADDR_W-1:0] ea,
    input  logic              user,
    output xlate_res_t        res
);
    logic       [NUM_ENTRIES-1:0] hit_vec;
    xlate_res_t                   cand [NUM_ENTRIES];
    logic       [NUM_ENTRIES-1:0] unused_rsvd;

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_cmp
        assign hit_vec[e]     = entry_hits(ent_up[e], ea, user);
        assign cand[e]        = entry_translate(ent_up[e], ent_lo[e], ea);
        assign unused_rsvd[e] = ^{ent_up[e].rsvd, ent_lo[e].rsvd};
    end

    // Scan from the top so the smallest matching index is the last to write
    always_comb begin
        res = '0;
        for (int e = NUM_ENTRIES - 1; e >= 0; e--) begin
            if (hit_vec[e]) res = cand[e];
        end
    end

endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
    import bat_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic              cfg_wr_dset,
    input  logic [IDX_W-1:0]  cfg_wr_idx,
    input  logic              cfg_wr_upper,
    input  logic [31:0]       cfg_wr_data,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    input  logic              req_fetch,
    input  logic              req_user,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [31:0]       rsp_paddr,
    output logic              rsp_rd,
    output logic              rsp_wr,
    output logic [31:0]       fault_addr
);
    upper_word_t sel_up [NUM_ENTRIES];
    lower_word_t sel_lo [NUM_ENTRIES];
    xlate_res_t  look;

    bat_entry_bank #(.NUM_ENTRIES(NUM_ENTRIES)) bank_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr_en),
        .wr_dset  (cfg_wr_dset),
        .wr_idx   (cfg_wr_idx),
        .wr_upper (cfg_wr_upper),
        .wr_data  (cfg_wr_data),
        .rd_dset  (!req_fetch),
        .sel_up   (sel_up),
        .sel_lo   (sel_lo)
    );

    bat_match_array #(.NUM_ENTRIES(NUM_ENTRIES)) match_i (
        .ent_up (sel_up),
        .ent_lo (sel_lo),
        .ea     (req_addr),
        .user   (req_user),
        .res    (look)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_miss   <= 1'b0;
            rsp_paddr  <= '0;
            rsp_rd     <= 1'b0;
            rsp_wr     <= 1'b0;
            fault_addr <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= req_valid && look.hit;
            rsp_miss  <= req_valid && !look.hit;
            rsp_paddr <= req_valid ? look.paddr : '0;
            rsp_rd    <= req_valid && look.rd;
            rsp_wr    <= req_valid && look.wr;
            if (req_valid && !look.hit) fault_addr <= req_addr;
        end
    end

endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic        rsp_miss,
    input logic [31:0] rsp_paddr,
    input logic        rsp_rd,
    input logic        rsp_wr,
    input logic [31:0] fault_addr
);
    AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rsp_hit && rsp_miss)); // R9

    AST_MISS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (rsp_paddr == 32'h0 && !rsp_rd && !rsp_wr)); // R9

    AST_MISS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (fault_addr == $past(req_addr))); // R9

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_valid && $onehot({rsp_hit, rsp_miss}))); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_hit && !rsp_miss)); // R10

    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$stable(fault_addr) |-> rsp_miss); // R11

    AST_WR_NEEDS_RD: assert property (@(posedge clk) disable iff (rst)
        rsp_wr |-> rsp_rd); // R7

    AST_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> (rsp_paddr[11:0] == 12'h000)); // R6
endmodule

bind bat_xlate bat_xlate_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_miss   (rsp_miss),
    .rsp_paddr  (rsp_paddr),
    .rsp_rd     (rsp_rd),
    .rsp_wr     (rsp_wr),
    .fault_addr (fault_addr)
);

// File: tb/bat_xlate_tb_top.sv
`timescale 1ns/1ps
module bat_xlate_tb_top;
    localparam int N     = 4;
    localparam int IDX_W = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_wr_en = 1'b0;
    logic             cfg_wr_dset = 1'b0;
    logic [IDX_W-1:0] cfg_wr_idx = '0;
    logic             cfg_wr_upper = 1'b0;
    logic [31:0]      cfg_wr_data = '0;
    logic             req_valid = 1'b0;
    logic [31:0]      req_addr = '0;
    logic             req_fetch = 1'b0;
    logic             req_user = 1'b0;
    logic             rsp_valid, rsp_hit, rsp_miss, rsp_rd, rsp_wr;
    logic [31:0]      rsp_paddr, fault_addr;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bat_xlate #(.NUM_ENTRIES(N)) dut_i (
        .clk(clk), .rst(rst),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_dset(cfg_wr_dset), .cfg_wr_idx(cfg_wr_idx),
        .cfg_wr_upper(cfg_wr_upper), .cfg_wr_data(cfg_wr_data),
        .req_valid(req_valid), .req_addr(req_addr), .req_fetch(req_fetch),
        .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_paddr(rsp_paddr), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr),
        .fault_addr(fault_addr)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr_word(logic dset, int idx, logic upper, logic [31:0] data);
        @(negedge clk);
        cfg_wr_en    = 1'b1;
        cfg_wr_dset  = dset;
        cfg_wr_idx   = IDX_W'(idx);
        cfg_wr_upper = upper;
        cfg_wr_data  = data;
        @(negedge clk);
        cfg_wr_en    = 1'b0;
    endtask

    // Issue one lookup; outputs are sampled at the negedge after the capture edge
    task automatic look(logic [31:0] addr, logic fetch, logic user);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = addr;
        req_fetch = fetch;
        req_user  = user;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_hit(string tag, logic [31:0] pa, logic rd, logic wr);
        chk({tag, " valid"}, 32'(rsp_valid), 1);
        chk({tag, " hit"},   32'(rsp_hit),   1);
        chk({tag, " miss"},  32'(rsp_miss),  0);
        chk({tag, " paddr"}, rsp_paddr,      pa);
        chk({tag, " rd"},    32'(rsp_rd),    32'(rd));
        chk({tag, " wr"},    32'(rsp_wr),    32'(wr));
    endtask

    task automatic expect_miss(string tag, logic [31:0] ea);
        chk({tag, " valid"}, 32'(rsp_valid), 1);
        chk({tag, " hit"},   32'(rsp_hit),   0);
        chk({tag, " miss"},  32'(rsp_miss),  1);
        chk({tag, " paddr"}, rsp_paddr,      0);
        chk({tag, " rdwr"},  32'({rsp_rd, rsp_wr}), 0);
        chk({tag, " fault"}, fault_addr,     ea);
    endtask

    task automatic t_reset();
        chk("R1 valid", 32'(rsp_valid), 0);
        chk("R1 hit",   32'(rsp_hit), 0);
        chk("R1 miss",  32'(rsp_miss), 0);
        chk("R1 fault", fault_addr, 0);
        look(32'h0000_1000, 1'b0, 1'b0);
        expect_miss("R1 empty data", 32'h0000_1000);
        look(32'h0000_2000, 1'b1, 1'b1);
        expect_miss("R1 empty fetch", 32'h0000_2000);
    endtask

    task automatic t_basic();
        wr_word(1'b1, 0, 1'b1, 32'h8000_0002);
        wr_word(1'b1, 0, 1'b0, 32'h1200_0002);
        look(32'h8001_5ABC, 1'b0, 1'b0);
        expect_hit("R6 R7 R12 data rw", 32'h1201_5000, 1'b1, 1'b1);
        chk("R11 fault after hit", fault_addr, 32'h0000_2000);
    endtask

    task automatic t_bank_select();
        look(32'h8001_5ABC, 1'b1, 1'b0);
        expect_miss("R2 fetch bank empty", 32'h8001_5ABC);
        wr_word(1'b0, 0, 1'b1, 32'h8000_0002);
        wr_word(1'b0, 0, 1'b0, 32'h3400_0001);
        look(32'h8001_5ABC, 1'b1, 1'b0);
        expect_hit("R2 R7 fetch ro", 32'h3401_5000, 1'b1, 1'b0);
        look(32'h8001_5ABC, 1'b0, 1'b0);
        expect_hit("R2 data unchanged", 32'h1201_5000, 1'b1, 1'b1);
    endtask

    task automatic t_top_nibble();
        look(32'h9001_5ABC, 1'b0, 1'b0);
        expect_miss("R3 nibble differs", 32'h9001_5ABC);
    endtask

    task automatic t_mask();
        // entry 1: full mask, both privilege bits, no permission
        wr_word(1'b1, 1, 1'b1, 32'h4000_1FFF);
        wr_word(1'b1, 1, 1'b0, 32'h5000_0000);
        look(32'h4ABC_DEF0, 1'b0, 1'b0);
        expect_hit("R4 R7 full mask noperm", 32'h5ABC_D000, 1'b0, 1'b0);
        // entry 2: mask on bits 18:17 only, supervisor only, read only
        wr_word(1'b1, 2, 1'b1, 32'h6000_000E);
        wr_word(1'b1, 2, 1'b0, 32'h7000_0001);
        look(32'h6006_1234, 1'b0, 1'b0);
        expect_hit("R4 R6 partial mask", 32'h7006_1000, 1'b1, 1'b0);
        look(32'h6008_0000, 1'b0, 1'b0);
        expect_miss("R4 unmasked bit", 32'h6008_0000);
    endtask

    task automatic t_priv();
        wr_word(1'b1, 3, 1'b1, 32'h2000_0001);
        wr_word(1'b1, 3, 1'b0, 32'h2200_0002);
        look(32'h2000_3000, 1'b0, 1'b0);
        expect_miss("R5 user-only entry, supervisor", 32'h2000_3000);
        look(32'h2000_3000, 1'b0, 1'b1);
        expect_hit("R5 user-only entry, user", 32'h2200_3000, 1'b1, 1'b1);
        look(32'h6006_0000, 1'b0, 1'b1);
        expect_miss("R5 supervisor-only entry, user", 32'h6006_0000);
    endtask

    task automatic t_priority();
        wr_word(1'b0, 1, 1'b1, 32'hA000_0003);
        wr_word(1'b0, 1, 1'b0, 32'hB000_0002);
        wr_word(1'b0, 3, 1'b1, 32'hA000_0003);
        wr_word(1'b0, 3, 1'b0, 32'hC000_0001);
        look(32'hA000_7FFF, 1'b1, 1'b0);
        expect_hit("R8 entry1 over entry3", 32'hB000_7000, 1'b1, 1'b1);
        wr_word(1'b0, 1, 1'b1, 32'hA000_0001);
        look(32'hA000_7FFF, 1'b1, 1'b0);
        expect_hit("R8 R12 entry3 after rewrite", 32'hC000_7000, 1'b1, 1'b0);
    endtask

    task automatic t_idle();
        logic [31:0] held;
        held = fault_addr;
        @(negedge clk);
        chk("R10 idle valid", 32'(rsp_valid), 0);
        chk("R10 idle hit/miss", 32'({rsp_hit, rsp_miss}), 0);
        chk("R11 idle fault hold", fault_addr, held);
        chk("R11 hold value", held, 32'h6006_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_bank_select();
        t_top_nibble();
        t_mask();
        t_priv();
        t_priority();
        t_idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule